// File: doc/BRIEF.md
# Byte-at-a-time DMA engine with control/status register

This block moves single bytes between an 8-bit peripheral controller and a local 64 KB byte buffer. The host programs three 16-bit registers through a simple register port: a control/status word, a buffer address and a byte count. After that, the peripheral paces the transfer. Each request the peripheral raises is answered with one acknowledge cycle. During that cycle one byte moves at the current buffer address. The address then steps up by one and the count steps down by one.

The direction bit selects the path. With direction 1 (towards the device), buffer read data is presented to the peripheral. With direction 0 (from the device), peripheral data is written into the buffer. Only in the towards-device direction is the peripheral told that the count has run out. It then performs one terminal cycle, which leaves the count at 0xFFFF and the address one byte past start plus count. The control/status word also holds the peripheral in reset and gates the peripheral's interrupt through to the host.

Top module: `bytedma_csr`

## Requirements
- R1: A 16-bit write to the control/status register (select 0) stores bit 0 as the active-low peripheral reset, bit 2 as interrupt enable and bit 3 as direction (1 = towards device, 0 = from device). All other written bits are ignored. After chip reset the three stored bits are 0.
- R2: A 16-bit read of select 0 returns the following word: bits 0, 2 and 3 as last written, bit 9 as the live peripheral interrupt input, bits 1 and 10 as 1, and every other bit as 0.
- R3: The address register (select 1) and the count register (select 2) are 16-bit read/write. An access with the 16-bit flag low is ignored on write and reads 0. Select 3 reads 0.
- R4: Each request from the peripheral produces exactly one acknowledge cycle, one clock after the request is first seen in idle. The request must fall before another cycle can start.
- R5: Every acknowledge cycle addresses the buffer at the current address. Afterwards the address increments and the count decrements, both modulo 2^16.
- R6: In the towards-device direction, end-of-process is driven high whenever the count is zero and the peripheral is out of reset.
- R7: In the from-device direction, end-of-process is never driven.
- R8: A towards-device transfer of N bytes that is followed by the terminal request leaves the count at 0xFFFF and the address at start + N + 1.
- R9: The host interrupt is high exactly when the peripheral interrupt input and the interrupt enable bit are both high.
- R10: While the stored reset bit is 0, the peripheral reset output is low, no acknowledge is given, and requests are ignored.
- R11: A host write to the address or count register takes priority over the step in the same clock. The next byte cycle uses the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| h_sel | input | 2 | Register select: 0 control/status, 1 address, 2 count |
| h_wr | input | 1 | Host write strobe |
| h_full | input | 1 | Access is 16 bits wide |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data for the selected register |
| drq | input | 1 | Peripheral byte request |
| dack | output | 1 | Byte acknowledge |
| eop | output | 1 | End-of-process to the peripheral |
| per_irq | input | 1 | Peripheral interrupt |
| per_rst_n | output | 1 | Peripheral reset, active low |
| host_irq | output | 1 | Gated interrupt to the host |
| pd_in | input | 8 | Byte from the peripheral |
| pd_out | output | 8 | Byte to the peripheral |
| buf_addr | output | 16 | Buffer byte address |
| buf_we | output | 1 | Buffer write enable |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data |

## Verification
The assertions check four properties on every cycle. An acknowledge never lasts two cycles. Each acknowledged byte moves the address up by one and the count down by one unless the host wrote that register. A terminal towards-device cycle leaves the count at 0xFFFF. Other behaviour shows up only in the bench's scenarios, where a behavioural model is compared against the block every cycle. This covers the end-of-process difference between the two directions, the overshoot of the final address, address wrap at 0xFFFF, the ignored narrow writes, requests arriving while reset is held, the read-back mix of control bits, constants and live status, and host writes landing mid-transfer.

// File: rtl/bytedma_csr.sv
module bytedma_csr #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    h_sel,
  input  logic          h_wr,
  input  logic          h_full,
  input  logic [15:0]   h_wdata,
  output logic [15:0]   h_rdata,
  input  logic          drq,
  output logic          dack,
  output logic          eop,
  input  logic          per_irq,
  output logic          per_rst_n,
  output logic          host_irq,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic [AW-1:0] buf_addr,
  output logic          buf_we,
  output logic [DW-1:0] buf_wdata,
  input  logic [DW-1:0] buf_rdata
);
  localparam logic [1:0] SEL_CSR = 2'd0, SEL_ADR = 2'd1, SEL_CNT = 2'd2;
  localparam logic [1:0] S_IDLE = 2'd0, S_XFER = 2'd1, S_HOLD = 2'd2;

  logic [1:0]    st;
  logic [AW-1:0] adr;
  logic [15:0]   cnt;
  logic          c_rstn, c_ien, c_dir;

  wire wr_ok  = h_wr && h_full;
  wire wr_csr = wr_ok && h_sel == SEL_CSR;
  wire wr_adr = wr_ok && h_sel == SEL_ADR;
  wire wr_cnt = wr_ok && h_sel == SEL_CNT;

  assign dack      = (st == S_XFER) && c_rstn;
  assign eop       = c_dir && (cnt == '0) && c_rstn;
  assign per_rst_n = c_rstn;
  assign host_irq  = per_irq && c_ien;
  assign buf_addr  = adr;
  assign buf_we    = dack && !c_dir;
  assign buf_wdata = pd_in;
  assign pd_out    = buf_rdata;

  always_comb begin
    h_rdata = '0;
    if (h_full) begin
      case (h_sel)
        SEL_CSR: h_rdata = {5'b0, 1'b1, per_irq, 5'b0, c_dir, c_ien, 1'b1, c_rstn};
        SEL_ADR: h_rdata = 16'(adr);
        SEL_CNT: h_rdata = cnt;
        default: h_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      adr    <= '0;
      cnt    <= '0;
      c_rstn <= 1'b0;
      c_ien  <= 1'b0;
      c_dir  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:  if (drq) st <= S_XFER;
        S_XFER:  st <= S_HOLD;
        default: if (!drq) st <= S_IDLE;
      endcase
      if (!c_rstn) st <= S_IDLE;

      if (wr_adr)    adr <= h_wdata[AW-1:0];
      else if (dack) adr <= adr + 1'b1;

      if (wr_cnt)    cnt <= h_wdata;
      else if (dack) cnt <= cnt - 1'b1;

      if (wr_csr) begin
        c_rstn <= h_wdata[0];
        c_ien  <= h_wdata[2];
        c_dir  <= h_wdata[3];
      end
    end
  end

  assert_one_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dack |=> !dack);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && !wr_adr) |=> buf_addr == $past(buf_addr) + 1'b1);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && !wr_cnt) |=> cnt == $past(cnt) - 1'b1);

  assert_terminal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dack && eop && !wr_cnt) |=> cnt == 16'hFFFF);
endmodule

// File: tb/tb_bytedma_csr.sv
module tb_bytedma_csr;
  logic clk = 0, rst_n = 0;
  logic [1:0] h_sel = 0;
  logic h_wr = 0, h_full = 1;
  logic [15:0] h_wdata = 0, h_rdata;
  logic drq = 0, dack, eop, per_irq = 0, per_rst_n, host_irq;
  logic [7:0] pd_in = 8'hC3, pd_out, buf_wdata, buf_rdata;
  logic [15:0] buf_addr;
  logic buf_we;

  int checks = 0, fails = 0, cyc = 0;
  int m_st = 0, m_adr = 0, m_cnt = 0;
  bit m_rstn = 0, m_ien = 0, m_dir = 0;

  assign buf_rdata = buf_addr[7:0] ^ 8'h5A;

  always #2 clk = ~clk;

  bytedma_csr dut (.clk, .rst_n, .h_sel, .h_wr, .h_full, .h_wdata, .h_rdata,
    .drq, .dack, .eop, .per_irq, .per_rst_n, .host_irq, .pd_in, .pd_out,
    .buf_addr, .buf_we, .buf_wdata, .buf_rdata);

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_adr = 0; m_cnt = 0; m_rstn = 0; m_ien = 0; m_dir = 0;
    end else begin
      int nst;
      bit dk;
      nst = m_st;
      if (m_st == 0 && drq) nst = 1;
      else if (m_st == 1) nst = 2;
      else if (m_st == 2 && !drq) nst = 0;
      if (!m_rstn) nst = 0;
      dk = (m_st == 1) && m_rstn;
      if (h_wr && h_full && h_sel == 1) m_adr = h_wdata;
      else if (dk) m_adr = (m_adr + 1) & 16'hFFFF;
      if (h_wr && h_full && h_sel == 2) m_cnt = h_wdata;
      else if (dk) m_cnt = (m_cnt - 1) & 16'hFFFF;
      if (h_wr && h_full && h_sel == 0) begin
        m_rstn = h_wdata[0]; m_ien = h_wdata[2]; m_dir = h_wdata[3];
      end
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit dk;
      int rd;
      dk = (m_st == 1) && m_rstn;
      chk(dack, dk, "R4 dack");
      chk(buf_addr, m_adr, "R5 buf_addr");
      chk(eop, m_dir && m_cnt == 0 && m_rstn, m_dir ? "R6 eop" : "R7 eop");
      chk(host_irq, per_irq && m_ien, "R9 host_irq");
      chk(per_rst_n, m_rstn, "R10 per_rst_n");
      chk(buf_we, dk && !m_dir, "R5 buf_we");
      if (dk) chk(m_dir ? pd_out : buf_wdata, m_dir ? buf_rdata : pd_in, "R5 data path");
      rd = 0;
      if (h_full) begin
        if (h_sel == 0) rd = 16'h0402 | (per_irq << 9) | (m_dir << 3) | (m_ien << 2) | m_rstn;
        else if (h_sel == 1) rd = m_adr;
        else if (h_sel == 2) rd = m_cnt;
      end
      chk(h_rdata, rd, h_sel == 0 ? "R1 R2 csr read" : "R3 reg read");
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d, input logic full = 1);
    h_sel = s; h_wdata = d; h_full = full; h_wr = 1;
    @(negedge clk);
    h_wr = 0; h_full = 1;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      drq = 1; repeat (3) @(negedge clk);
      drq = 0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic rd_chk(input logic [1:0] s, input int exp, input string tag);
    h_sel = s; #1;
    chk(h_rdata, exp, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd_chk(0, 16'h0402, "R1 reset state");
    rst_n = 1;
    @(negedge clk);
    rd_chk(0, 16'h0402, "R1 csr after reset");
    wr(0, 16'hFFFF);
    rd_chk(0, 16'h040F, "R1 R2 only bits 0 2 3 kept");
    wr(0, 16'h0000, 0);
    rd_chk(0, 16'h040F, "R3 narrow csr write ignored");
    h_full = 0; rd_chk(1, 0, "R3 narrow read zero"); h_full = 1;
    per_irq = 1; rd_chk(0, 16'h060F, "R2 live irq bit9");
    chk(host_irq, 1, "R9 enabled");
    wr(0, 16'h0009);
    chk(host_irq, 0, "R9 disabled");
    per_irq = 0;
    wr(1, 16'h0100); wr(2, 16'd3);
    pulse(3);
    chk(eop, 1, "R6 eop at zero");
    pulse(1);
    rd_chk(2, 16'hFFFF, "R8 count wraps");
    rd_chk(1, 16'h0104, "R8 address overshoot");
    wr(0, 16'h0001);
    wr(1, 16'hFFFE); wr(2, 16'd2);
    pulse(3);
    chk(eop, 0, "R7 no eop from device");
    rd_chk(1, 16'h0001, "R5 address wrap");
    wr(0, 16'h0000);
    wr(1, 16'h0200);
    pulse(2);
    rd_chk(1, 16'h0200, "R10 drq ignored in reset");
    wr(0, 16'h0001);
    drq = 1; @(negedge clk);
    h_sel = 1; h_wdata = 16'h0300; h_wr = 1; @(negedge clk); h_wr = 0;
    drq = 0; repeat (2) @(negedge clk);
    rd_chk(1, 16'h0300, "R11 host write wins");
    pulse(1);
    rd_chk(1, 16'h0301, "R11 next byte uses new address");
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule